// File: doc/BRIEF.md
# Two-Column Keypad Scanner with Serial Readout

This block scans a 60-position keypad at a fixed rate. The switches are wired as two columns of 30, and each column shares one common line. To scan a column, the block pulls that column's common line low and reads two switches straight from two input pins. It then pulses a latch line, which captures the other 28 switches of the column into external parallel-in shift registers. The block releases the column line and clocks the 28 captured bits in over a single serial data input. The two columns are scanned one after the other.

The switch positions follow a fixed order, and the block turns them into one 7-bit key code. The upper two bits give the prefix: plain, M, or handset-off. The lower five bits give the digit, 0 to 19. A scan that finds exactly one pressed switch produces a one-cycle valid pulse together with its code. A scan that finds two or more pressed switches produces an error pulse, and its result is discarded. A scan with no pressed switch produces nothing. The scan rate and the serial clock rate are parameters, given in hertz against the system clock.

Top module: `kp2col_scanner`

## Requirements
- R1: A scan starts once every PERIOD = CLK_HZ/SCAN_HZ clock cycles. The first column line falls exactly PERIOD cycles after its previous fall.
- R2: Column 1 is selected by driving col_n[0] low, and column 2 by driving col_n[1] low. Column 1 is scanned first. The two lines are never low together.
- R3: Each column produces exactly one latch pulse. The latch is high only while that column's line is low. Both column lines are high whenever the serial clock is high.
- R4: Each column produces exactly 28 rising edges of sclk. sclk stays high for HALF = CLK_HZ/(2*SHIFT_HZ) cycles at a time. sdi is sampled just before each rise, and the first bit after the latch pulse is shifted bit 1.
- R5: Switches are active low, so an input that reads 1 is not pressed. A scan with no pressed switch produces neither key_valid nor key_error.
- R6: Column 1 key codes are as follows. Direct input 0 gives 0x08 and direct input 1 gives 0x09. Shifted bits 1..8 give 0x07 down to 0x00. Bits 9..18 give 0x13 down to 0x0A. Bits 19..28 give 0x49 down to 0x40.
- R7: Column 2 key codes are as follows. Direct input 0 gives 0x28 and direct input 1 gives 0x29. Shifted bits 1..8 give 0x27 down to 0x20. Bits 9..18 give 0x33 down to 0x2A. Bits 19..28 give 0x53 down to 0x4A.
- R8: key_code[6:5] is the prefix: 0 for plain, 1 for M, 2 for handset-off. key_code[4:0] is the digit number.
- R9: If two or more switches read pressed in one scan, in the same column or in different columns, key_error pulses for one cycle. key_valid stays low and key_code keeps its previous value.
- R10: key_valid is a one-cycle pulse. It comes after both columns have been scanned with exactly one press. key_code changes only together with key_valid.
- R11: While in reset, col_n is 2'b11, latch and sclk are 0, key_valid and key_error are 0, and key_code is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| direct_n | input | 2 | Two directly read switches of the active column, active low |
| sdi | input | 1 | Serial data from the external shift registers, active low |
| col_n | output | 2 | Column common lines, active low |
| latch | output | 1 | Parallel-load pulse for the external shift registers |
| sclk | output | 1 | Serial shift clock |
| key_code | output | 7 | Code of the last valid key |
| key_valid | output | 1 | One-cycle pulse: a single key was found |
| key_error | output | 1 | One-cycle pulse: more than one key was found |

## Verification
The assertions assume three things about the inputs. First, the switches do not change while a scan is in progress. Second, the external registers present shifted bit 1 after the latch pulse and advance on each rising edge of sclk. Third, the parameters make a full two-column scan shorter than the scan period, so a new start never arrives before the sequencer is idle. The stimulus meets these assumptions in three ways. It changes the pressed switches only in the middle of the idle gap between scans. It models the shift registers so that they load on the latch pulse and shift on the rising edge of sclk. It uses a short scan period, which still leaves more than a thousand idle cycles after each scan.

// File: rtl/kp_pkg.sv
package kp_pkg;
  localparam int DIRECT_KEYS = 2;
  localparam int SHIFT_BITS  = 28;
  localparam int IDX_W       = $clog2(SHIFT_BITS);
  localparam int POS_W       = 5;
  localparam int CODE_W      = 7;

  typedef enum logic [2:0] {
    ST_IDLE, ST_SETTLE, ST_LHI, ST_LLO, ST_SHIFT
  } scan_st_e;

  // Column position map: positions 0..1 are the direct pins, 2..29 are shifted bits 1..28
  function automatic logic [CODE_W-1:0] pos2code(input logic col, input logic [POS_W-1:0] pos);
    logic [1:0] pfx;
    logic [4:0] dig;
    logic [5:0] wide;
    pfx  = {1'b0, col};
    wide = '0;
    if (pos < 5'd2)       dig = 5'd8 + pos;
    else if (pos < 5'd10) dig = 5'd9 - pos;
    else if (pos < 5'd20) dig = 5'd29 - pos;
    else begin
      pfx  = 2'd2;
      wide = (col ? 6'd39 : 6'd29) - {1'b0, pos};
      dig  = wide[4:0];
    end
    return {pfx, dig};
  endfunction
endpackage

// File: rtl/kp_tick.sv
module kp_tick #(
  parameter int PERIOD = 1000
) (
  input  logic clk,
  input  logic rst_n,
  output logic start
);
  localparam int CW = (PERIOD > 2) ? $clog2(PERIOD) : 1;

  logic [CW-1:0] cnt_q, cnt_d;

  always_comb begin
    start = (cnt_q == CW'(PERIOD - 1));
    cnt_d = start ? '0 : cnt_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_d;
  end
endmodule

// File: rtl/kp_seq.sv
module kp_seq
  import kp_pkg::*;
#(
  parameter int HALF = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start,
  output logic [1:0]       col_n,
  output logic             latch,
  output logic             sclk,
  output logic             dir_stb,
  output logic             bit_stb,
  output logic             cur_col,
  output logic [IDX_W-1:0] bit_idx,
  output logic             scan_done
);
  localparam int TW = (HALF > 1) ? $clog2(HALF) : 1;

  scan_st_e         st_q, st_d;
  logic             col_q, col_d;
  logic [TW-1:0]    tmr_q, tmr_d;
  logic [IDX_W-1:0] idx_q, idx_d;
  logic             sclk_q, sclk_d;
  logic             tmr_last, in_col, last_bit;

  always_comb begin
    tmr_last = (tmr_q == TW'(HALF - 1));
    last_bit = (idx_q == IDX_W'(SHIFT_BITS - 1));
    st_d   = st_q;
    col_d  = col_q;
    idx_d  = idx_q;
    sclk_d = sclk_q;
    tmr_d  = tmr_last ? '0 : tmr_q + 1'b1;
    case (st_q)
      ST_IDLE: begin
        tmr_d = '0;
        if (start) begin
          st_d  = ST_SETTLE;
          col_d = 1'b0;
        end
      end
      ST_SETTLE: if (tmr_last) st_d = ST_LHI;
      ST_LHI:    if (tmr_last) st_d = ST_LLO;
      ST_LLO: if (tmr_last) begin
        st_d   = ST_SHIFT;
        idx_d  = '0;
        sclk_d = 1'b0;
      end
      ST_SHIFT: if (tmr_last) begin
        if (!sclk_q) sclk_d = 1'b1;
        else begin
          sclk_d = 1'b0;
          if (last_bit) begin
            idx_d = '0;
            if (col_q) st_d = ST_IDLE;
            else begin
              st_d  = ST_SETTLE;
              col_d = 1'b1;
            end
          end else idx_d = idx_q + 1'b1;
        end
      end
      default: st_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q   <= ST_IDLE;
      col_q  <= 1'b0;
      tmr_q  <= '0;
      idx_q  <= '0;
      sclk_q <= 1'b0;
    end else begin
      st_q   <= st_d;
      col_q  <= col_d;
      tmr_q  <= tmr_d;
      idx_q  <= idx_d;
      sclk_q <= sclk_d;
    end
  end

  always_comb begin
    in_col    = (st_q == ST_SETTLE) || (st_q == ST_LHI) || (st_q == ST_LLO);
    col_n[0]  = !(in_col && !col_q);
    col_n[1]  = !(in_col && col_q);
    latch     = (st_q == ST_LHI);
    sclk      = sclk_q;
    dir_stb   = (st_q == ST_SETTLE) && tmr_last;
    bit_stb   = (st_q == ST_SHIFT) && tmr_last && !sclk_q;
    cur_col   = col_q;
    bit_idx   = idx_q;
    scan_done = (st_q == ST_SHIFT) && tmr_last && sclk_q && last_bit && col_q;
  end

  AST_START_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    start |-> (st_q == ST_IDLE)); // R1
  AST_ONE_COLUMN: assert property (@(posedge clk) disable iff (!rst_n)
    col_n != 2'b00); // R2
  AST_LATCH_IN_COLUMN: assert property (@(posedge clk) disable iff (!rst_n)
    latch |-> (col_n != 2'b11)); // R3
  AST_SHIFT_RELEASED: assert property (@(posedge clk) disable iff (!rst_n)
    sclk |-> (col_n == 2'b11)); // R3
endmodule

// File: rtl/kp_decode.sv
module kp_decode
  import kp_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic              dir_stb,
  input  logic              bit_stb,
  input  logic              cur_col,
  input  logic [IDX_W-1:0]  bit_idx,
  input  logic [1:0]        direct_n,
  input  logic              sdi,
  input  logic              scan_done,
  output logic [CODE_W-1:0] key_code,
  output logic              key_valid,
  output logic              key_error
);
  logic [1:0]        cnt_q, cnt_d, hits;
  logic [2:0]        sum;
  logic [CODE_W-1:0] cand_q, cand_d, kc_q, kc_d;
  logic              val_d, err_d, val_q, err_q;
  logic [POS_W-1:0]  sh_pos;

  always_comb begin
    sh_pos = POS_W'(bit_idx) + POS_W'(DIRECT_KEYS);
    hits   = 2'd0;
    if (dir_stb)      hits = {1'b0, !direct_n[0]} + {1'b0, !direct_n[1]};
    else if (bit_stb) hits = {1'b0, !sdi};
    sum   = {1'b0, cnt_q} + {1'b0, hits};
    cnt_d = start ? 2'd0 : ((sum > 3'd2) ? 2'd2 : sum[1:0]);

    cand_d = cand_q;
    if (dir_stb && !direct_n[0])      cand_d = pos2code(cur_col, POS_W'(0));
    else if (dir_stb && !direct_n[1]) cand_d = pos2code(cur_col, POS_W'(1));
    else if (bit_stb && !sdi)         cand_d = pos2code(cur_col, sh_pos);

    val_d = scan_done && (cnt_q == 2'd1);
    err_d = scan_done && (cnt_q == 2'd2);
    kc_d  = val_d ? cand_q : kc_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q  <= '0;
      cand_q <= '0;
      kc_q   <= '0;
      val_q  <= 1'b0;
      err_q  <= 1'b0;
    end else begin
      cnt_q  <= cnt_d;
      cand_q <= cand_d;
      kc_q   <= kc_d;
      val_q  <= val_d;
      err_q  <= err_d;
    end
  end

  assign key_code  = kc_q;
  assign key_valid = val_q;
  assign key_error = err_q;

  AST_VALID_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    key_valid |=> !key_valid); // R10
  AST_CODE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !key_valid |-> $stable(key_code)); // R10
  AST_ERR_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
    !(key_valid && key_error)); // R9
  AST_ERR_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    key_error |=> !key_error); // R9
endmodule

// File: rtl/kp2col_scanner.sv
module kp2col_scanner
  import kp_pkg::*;
#(
  parameter int CLK_HZ   = 100_000_000,
  parameter int SCAN_HZ  = 100,
  parameter int SHIFT_HZ = 306_000
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [1:0]        direct_n,
  input  logic              sdi,
  output logic [1:0]        col_n,
  output logic              latch,
  output logic              sclk,
  output logic [CODE_W-1:0] key_code,
  output logic              key_valid,
  output logic              key_error
);
  localparam int PERIOD   = CLK_HZ / SCAN_HZ;
  localparam int HALF_RAW = CLK_HZ / (2 * SHIFT_HZ);
  localparam int HALF     = (HALF_RAW < 1) ? 1 : HALF_RAW;

  logic             start, dir_stb, bit_stb, cur_col, scan_done;
  logic [IDX_W-1:0] bit_idx;

  kp_tick #(.PERIOD(PERIOD)) u_tick (
    .clk(clk), .rst_n(rst_n), .start(start)
  );

  kp_seq #(.HALF(HALF)) u_seq (
    .clk(clk), .rst_n(rst_n), .start(start),
    .col_n(col_n), .latch(latch), .sclk(sclk),
    .dir_stb(dir_stb), .bit_stb(bit_stb), .cur_col(cur_col),
    .bit_idx(bit_idx), .scan_done(scan_done)
  );

  kp_decode u_dec (
    .clk(clk), .rst_n(rst_n), .start(start),
    .dir_stb(dir_stb), .bit_stb(bit_stb), .cur_col(cur_col),
    .bit_idx(bit_idx), .direct_n(direct_n), .sdi(sdi),
    .scan_done(scan_done),
    .key_code(key_code), .key_valid(key_valid), .key_error(key_error)
  );
endmodule

// File: tb/kp2col_scanner_test.sv
module kp2col_scanner_test;
  localparam int CLK_HZ   = 100_000_000;
  localparam int SCAN_HZ  = 50_000;
  localparam int SHIFT_HZ = 10_000_000;
  localparam int PERIOD   = CLK_HZ / SCAN_HZ;         // 2000 cycles
  localparam int HALF     = CLK_HZ / (2 * SHIFT_HZ);  // 5 cycles
  localparam int WINDOW   = 1000;

  logic       clk = 1'b0;
  logic       rst_n;
  logic [1:0] direct_n;
  logic       sdi;
  logic [1:0] col_n;
  logic       latch, sclk;
  logic [6:0] key_code;
  logic       key_valid, key_error;

  logic [29:0] k0_n, k1_n;
  logic [27:0] sr;
  int total = 0, bad = 0, cyc = 0;

  logic [8:0] exp_q[$];
  string      req_q[$];
  logic [6:0] last_valid;
  string      prev_req;

  always #5 clk = ~clk;

  kp2col_scanner #(.CLK_HZ(CLK_HZ), .SCAN_HZ(SCAN_HZ), .SHIFT_HZ(SHIFT_HZ)) uut (
    .clk(clk), .rst_n(rst_n), .direct_n(direct_n), .sdi(sdi),
    .col_n(col_n), .latch(latch), .sclk(sclk),
    .key_code(key_code), .key_valid(key_valid), .key_error(key_error)
  );

  // keypad and external shift-register model
  assign direct_n = !col_n[0] ? k0_n[1:0] : (!col_n[1] ? k1_n[1:0] : 2'b11);
  assign sdi = sr[27];

  always @(posedge latch) begin
    for (int i = 0; i < 28; i++)
      sr[27-i] <= !col_n[0] ? k0_n[i+2] : (!col_n[1] ? k1_n[i+2] : 1'b1);
  end
  always @(posedge sclk) sr <= {sr[26:0], 1'b1};

  always @(posedge clk) if (rst_n) cyc <= cyc + 1;

  task automatic check(input bit ok, input string req, input string what, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  // scoreboard monitor
  always @(negedge clk) begin
    if (rst_n && (key_valid || key_error)) begin
      if (exp_q.size() == 0) begin
        check(1'b0, "R5", "unexpected result", {key_valid, key_error}, 0);
      end else begin
        logic [8:0] e;
        string r;
        e = exp_q.pop_front();
        r = req_q.pop_front();
        check(key_valid == (e[8:7] == 2'd1) && key_error == (e[8:7] == 2'd2), r, "result kind",
              {key_valid, key_error}, (e[8:7] == 2'd1) ? 2 : 1);
        check(key_code == e[6:0], r, "key_code", key_code, e[6:0]);
      end
    end
  end

  // waveform monitors
  logic [1:0] col_p = 2'b11;
  logic latch_p = 1'b0, sclk_p = 1'b0, seen_c0 = 1'b0;
  int last_fall = -1, n_latch = 0, n_sclk = 0, hi_len = 0;
  always @(negedge clk) begin
    if (rst_n) begin
      if (col_n == 2'b00) check(1'b0, "R2", "both columns low", col_n, 3);
      if (col_p[0] && !col_n[0]) begin
        if (last_fall >= 0) begin
          check(cyc - last_fall == PERIOD, "R1", "scan spacing", cyc - last_fall, PERIOD);
          check(n_latch == 2, "R3", "latch pulses per scan", n_latch, 2);
          check(n_sclk == 56, "R4", "sclk rises per scan", n_sclk, 56);
        end
        last_fall = cyc; n_latch = 0; n_sclk = 0; seen_c0 = 1'b1;
      end
      if (col_p[1] && !col_n[1]) begin
        check(seen_c0 && col_n[0], "R2", "column 2 after column 1", {seen_c0, col_n[0]}, 3);
        seen_c0 = 1'b0;
      end
      if (!latch_p && latch) begin
        n_latch++;
        check(col_n != 2'b11, "R3", "latch while column active", col_n, 1);
      end
      if (!sclk_p && sclk) begin
        n_sclk++;
        check(col_n == 2'b11, "R3", "columns released while shifting", col_n, 3);
      end
      if (sclk) hi_len++;
      if (sclk_p && !sclk) begin
        check(hi_len == HALF, "R4", "sclk high time", hi_len, HALF);
        hi_len = 0;
      end
      col_p = col_n; latch_p = latch; sclk_p = sclk;
    end
  end

  task automatic press(input logic [6:0] code);
    int d, pos;
    logic c;
    d = int'(code[4:0]);
    c = (code[6:5] == 2'd1);
    if (code[6:5] == 2'd2) begin
      c   = (d >= 10);
      pos = (d <= 9) ? 29 - d : 39 - d;
    end else begin
      pos = (d == 8) ? 0 : (d == 9) ? 1 : (d <= 7) ? 9 - d : 29 - d;
    end
    if (c) k1_n[pos] = 1'b0;
    else   k0_n[pos] = 1'b0;
  endtask

  // driver: kind 0 = nothing expected, 1 = valid key, 2 = error
  task automatic run_case(input int kind, input int nkeys, input logic [6:0] a,
                          input logic [6:0] b, input string req);
    @(negedge clk);
    while ((cyc % PERIOD) != WINDOW) @(negedge clk);
    check(exp_q.size() == 0, prev_req, "result count after scan", exp_q.size(), 0);
    exp_q.delete(); req_q.delete();
    k0_n = '1; k1_n = '1;
    if (nkeys >= 1) press(a);
    if (nkeys >= 2) press(b);
    if (kind == 1) begin
      exp_q.push_back({2'd1, a}); req_q.push_back(req); last_valid = a;
    end else if (kind == 2) begin
      exp_q.push_back({2'd2, last_valid}); req_q.push_back(req);
    end
    prev_req = req;
  endtask

  initial begin
    rst_n = 1'b0; k0_n = '1; k1_n = '1; sr = '1;
    last_valid = 7'h00; prev_req = "R11";
    repeat (3) @(negedge clk);
    check(col_n == 2'b11, "R11", "reset col_n", col_n, 3);
    check(!latch && !sclk, "R11", "reset latch/sclk", {latch, sclk}, 0);
    check(!key_valid && !key_error, "R11", "reset flags", {key_valid, key_error}, 0);
    check(key_code == 7'h00, "R11", "reset key_code", key_code, 0);
    rst_n = 1'b1;
    run_case(0, 0, 7'h00, 7'h00, "R5");   // no key
    run_case(1, 1, 7'h08, 7'h00, "R6");   // column 1 direct 0
    run_case(1, 1, 7'h09, 7'h00, "R6");   // column 1 direct 1
    run_case(1, 1, 7'h29, 7'h00, "R7");   // column 2 direct 1
    run_case(1, 1, 7'h07, 7'h00, "R6");   // first shifted bit
    run_case(1, 1, 7'h00, 7'h00, "R6");   // bit 8
    run_case(1, 1, 7'h13, 7'h00, "R6");   // bit 9
    run_case(1, 1, 7'h0A, 7'h00, "R6");   // bit 18
    run_case(1, 1, 7'h49, 7'h00, "R8");   // handset-off prefix, bit 19
    run_case(1, 1, 7'h40, 7'h00, "R6");   // last shifted bit, column 1
    run_case(1, 1, 7'h53, 7'h00, "R7");   // column 2 bit 19
    run_case(1, 1, 7'h4A, 7'h00, "R7");   // column 2 last bit
    run_case(1, 1, 7'h25, 7'h00, "R8");   // M prefix
    run_case(2, 2, 7'h03, 7'h11, "R9");   // two in one column
    run_case(2, 2, 7'h08, 7'h28, "R9");   // one in each column
    run_case(2, 2, 7'h28, 7'h29, "R9");   // both direct pins
    run_case(0, 0, 7'h00, 7'h00, "R10");  // quiet scan, code held
    check(key_code == last_valid, "R10", "key_code held", key_code, last_valid);
    run_case(1, 1, 7'h33, 7'h00, "R10");
    run_case(0, 0, 7'h00, 7'h00, "R5");
    run_case(0, 0, 7'h00, 7'h00, "R5");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (150_000) @(posedge clk);
    total++; bad++;
    $display("FAIL watchdog: actual=expired expected=finished");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule